// File: doc/BRIEF.md
# Test access port with configuration-load gating

This block is the target side of an IEEE 1149.1 test access port. It lets an external tester load a device's configuration bitstream serially through TDI. A 3-bit instruction register selects one of three instructions: a bypass instruction, a sample instruction, and a configure instruction. Any opcode it does not recognise acts as bypass. While the configure instruction is current, the block does three things:

- It marks which TCK rising edges a downstream configuration engine should take as configuration clocks.
- It echoes TDI on TDO and on a separate daisy-chain output until a preamble and a 24-bit length field have gone past.
- It fires a one-cycle pulse that starts the clearing of configuration memory.

The block also controls which instructions are allowed during a load. Once the engine has released its memory-clear flag, the load is locked and cannot be disturbed, except that loading the configure opcode again cancels it. After a reported failure, the configure opcode is refused until the device is reset through `prog_n`. Each sampled opcode is decoded at the TCK rising edge that leaves Update-IR. Every register in the block uses that TCK rising edge.

Top module: `jtc_cfg_tap`

## Requirements
- R1: The controller follows the IEEE 1149.1 16-state diagram on TMS at each TCK rising edge. `prog_n` low forces Test-Logic-Reset asynchronously, and five rising edges with TMS high reach Test-Logic-Reset from any state.
- R2: The instruction shift register loads the pattern 001 in Capture-IR. It shifts one bit toward its LSB, with TDI entering at the MSB, on every rising edge taken while in Shift-IR, including the edge that leaves the state. In Shift-IR, TDO shows the LSB, so the first bit out is 1 and the next two are 0.
- R3: The opcode is shifted in LSB first: 101 is configure, 001 is sample, 111 is bypass, and any other value is bypass. The decode takes effect on the edge leaving Update-IR. When configure is accepted, `clr_start` is high for exactly the one cycle after that edge.
- R4: `cfg_clk_en` is high only when configure is current, the controller is in Shift-DR, and `init_rel` is high.
- R5: Under bypass, sample, or an unknown opcode, a 1-bit register loads 0 in Capture-DR. In Shift-DR, TDO shows that register, so TDO gives 0 first and then TDI delayed by one edge. Outside both shift states TDO is 0.
- R6: While `cfg_clk_en` is high and the length field has not been fully received, `dout` and `tdo` equal `tdi`. With configure current in Shift-DR and `init_rel` low, `tdo` is 0. `dout` is 1 whenever it is not echoing.
- R7: The stream is counted only on edges where `cfg_clk_en` is high. The preamble is the bit order 1,0,0,1,0, and the 24 bits after it are the length field. From the edge that takes the 24th length bit, `dout` and `tdo` hold 1.
- R8: A rising edge with configure current and `init_rel` high locks the load. While locked, other opcodes and Test-Logic-Reset leave configure current. A `cfg_done` pulse ends the lock, and no new lock forms until configure is accepted again.
- R9: Loading 101 while locked cancels the load: bypass becomes current and there is no `clr_start` pulse. A later 101 is accepted as a fresh configure.
- R10: `cfg_fail` seen while configure is current makes bypass current and ends the lock. From then on 101 is refused and acts as bypass until `prog_n` is asserted.
- R11: Test-Logic-Reset makes bypass current when no load is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| prog_n | input | 1 | Asynchronous active-low reset (power-up or program) |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| init_rel | input | 1 | Memory clearing finished, ready for stream data |
| cfg_done | input | 1 | Configuration engine finished |
| cfg_fail | input | 1 | Configuration engine reports an error |
| tdo | output | 1 | Test data out |
| dout | output | 1 | Daisy-chain serial data out |
| cfg_clk_en | output | 1 | Current TCK rising edge is a configuration clock |
| clr_start | output | 1 | One-cycle start of configuration memory clearing |

## Verification
The bench pushes a full stream through the block and checks `dout` on every bit. A tracker that got the preamble match or the length count wrong would stop echoing one edge early or late. The bench also looks for decode bugs:
- A wrong lock would let a sample opcode or Test-Logic-Reset drop configure in the middle of a load, which shows up as `cfg_clk_en` falling in Shift-DR.
- A missing cancel rule would re-pulse `clr_start` on a repeated 101.
- A failure flag that is not sticky would accept 101 again.

Random bit streams under bypass and under an unknown opcode test the one-edge delay of the bypass register.

// File: rtl/jtc_pkg.sv
package jtc_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI, ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR,
        ST_UPD_DR, ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_st_e;

    typedef enum logic [1:0] {
        MODE_BYP, MODE_SMP, MODE_CFG
    } ir_mode_e;

    localparam int IR_W = 3;
    localparam logic [IR_W-1:0] OP_CFG = 3'b101;
    localparam logic [IR_W-1:0] OP_SMP = 3'b001;
    localparam logic [IR_W-1:0] OP_BYP = 3'b111;

    function automatic tap_st_e tap_next(tap_st_e s, logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_RTI;
            ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            default:   return m ? ST_SEL_DR : ST_RTI;
        endcase
    endfunction

endpackage

// File: rtl/jtc_tap_fsm.sv
module jtc_tap_fsm
    import jtc_pkg::*;
(
    input  logic    tck,
    input  logic    prog_n,
    input  logic    tms,
    output tap_st_e st_q
);
    tap_st_e st_d;

    always_comb st_d = tap_next(st_q, tms);

    always_ff @(posedge tck or negedge prog_n) begin
        if (!prog_n) st_q <= ST_TLR;
        else         st_q <= st_d;
    end
endmodule

// File: rtl/jtc_ir_shift.sv
module jtc_ir_shift
    import jtc_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         prog_n,
    input  tap_st_e      st_q,
    input  logic         tdi,
    output logic [W-1:0] sh_q
);
    localparam logic [W-1:0] CAP_PAT = {{(W-1){1'b0}}, 1'b1};
    logic [W-1:0] sh_d;

    always_comb begin
        sh_d = sh_q;
        if (st_q == ST_CAP_IR)     sh_d = CAP_PAT;
        else if (st_q == ST_SH_IR) sh_d = {tdi, sh_q[W-1:1]};
    end

    always_ff @(posedge tck or negedge prog_n) begin
        if (!prog_n) sh_q <= CAP_PAT;
        else         sh_q <= sh_d;
    end
endmodule

// File: rtl/jtc_stream_trk.sv
module jtc_stream_trk #(
    parameter int          PRE_W   = 5,
    parameter logic [4:0]  PRE_PAT = 5'b10010,
    parameter int          LEN_W   = 24
) (
    input  logic tck,
    input  logic prog_n,
    input  logic restart,
    input  logic en,
    input  logic tdi,
    output logic past_q
);
    localparam int CW = $clog2(LEN_W);
    typedef enum logic [1:0] {PH_HUNT, PH_LEN, PH_PAST} ph_e;
    typedef struct packed {
        ph_e              ph;
        logic [CW-1:0]    cnt;
        logic [PRE_W-1:0] hist;
    } trk_s;

    trk_s q, d;
    logic [PRE_W-1:0] hist_nx;

    always_comb begin
        d       = q;
        hist_nx = {q.hist[PRE_W-2:0], tdi};
        if (restart) begin
            d = '{ph: PH_HUNT, cnt: '0, hist: '0};
        end else if (en) begin
            d.hist = hist_nx;
            case (q.ph)
                PH_HUNT: if (hist_nx == PRE_PAT[PRE_W-1:0]) begin
                    d.ph  = PH_LEN;
                    d.cnt = '0;
                end
                PH_LEN: begin
                    if (q.cnt == CW'(LEN_W - 1)) d.ph = PH_PAST;
                    else                         d.cnt = q.cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge tck or negedge prog_n) begin
        if (!prog_n) q <= '{ph: PH_HUNT, cnt: '0, hist: '0};
        else         q <= d;
    end

    assign past_q = (q.ph == PH_PAST);
endmodule

// File: rtl/jtc_cfg_tap.sv
module jtc_cfg_tap
    import jtc_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic tck,
    input  logic prog_n,
    input  logic tms,
    input  logic tdi,
    input  logic init_rel,
    input  logic cfg_done,
    input  logic cfg_fail,
    output logic tdo,
    output logic dout,
    output logic cfg_clk_en,
    output logic clr_start
);
    typedef struct packed {
        ir_mode_e mode;
        logic     lock;
        logic     fin;
        logic     fail;
        logic     clr;
        logic     byp;
    } ctl_s;

    tap_st_e         st_q;
    logic [IR_W-1:0] ir_sh;
    logic            past;
    logic            restart;
    ctl_s            q, d;

    jtc_tap_fsm u_fsm (.tck(tck), .prog_n(prog_n), .tms(tms), .st_q(st_q));

    jtc_ir_shift #(.W(IR_W)) u_ir (
        .tck(tck), .prog_n(prog_n), .st_q(st_q), .tdi(tdi), .sh_q(ir_sh)
    );

    jtc_stream_trk #(.LEN_W(LEN_W)) u_trk (
        .tck(tck), .prog_n(prog_n), .restart(restart), .en(cfg_clk_en),
        .tdi(tdi), .past_q(past)
    );

    always_comb begin
        d       = q;
        d.clr   = 1'b0;
        restart = 1'b0;
        if (st_q == ST_CAP_DR)     d.byp = 1'b0;
        else if (st_q == ST_SH_DR) d.byp = tdi;

        if (cfg_fail && q.mode == MODE_CFG) begin
            d.fail = 1'b1;
            d.mode = MODE_BYP;
            d.lock = 1'b0;
        end else if (st_q == ST_UPD_IR) begin
            if (q.lock) begin
                if (ir_sh == OP_CFG) begin
                    d.mode = MODE_BYP;
                    d.lock = 1'b0;
                end
            end else if (ir_sh == OP_CFG && !q.fail) begin
                d.mode  = MODE_CFG;
                d.fin   = 1'b0;
                d.clr   = 1'b1;
                restart = 1'b1;
            end else if (ir_sh == OP_SMP) begin
                d.mode = MODE_SMP;
            end else begin
                d.mode = MODE_BYP;
            end
        end else if (st_q == ST_TLR && !q.lock) begin
            d.mode = MODE_BYP;
        end else if (q.lock && cfg_done) begin
            d.lock = 1'b0;
            d.fin  = 1'b1;
        end else if (q.mode == MODE_CFG && init_rel && !q.fin) begin
            d.lock = 1'b1;
        end
    end

    always_ff @(posedge tck or negedge prog_n) begin
        if (!prog_n) q <= '{mode: MODE_BYP, lock: 1'b0, fin: 1'b0, fail: 1'b0, clr: 1'b0, byp: 1'b0};
        else         q <= d;
    end

    assign cfg_clk_en = (q.mode == MODE_CFG) && (st_q == ST_SH_DR) && init_rel;
    assign clr_start  = q.clr;
    assign dout       = (cfg_clk_en && !past) ? tdi : 1'b1;

    always_comb begin
        tdo = 1'b0;
        if (st_q == ST_SH_IR)
            tdo = ir_sh[0];
        else if (st_q == ST_SH_DR) begin
            if (q.mode == MODE_CFG) tdo = cfg_clk_en ? (past | tdi) : 1'b0;
            else                    tdo = q.byp;
        end
    end
endmodule

// File: rtl/jtc_cfg_tap_chk.sv
module jtc_cfg_tap_chk
    import jtc_pkg::*;
(
    input logic            tck,
    input logic            prog_n,
    input logic            tdi,
    input logic            init_rel,
    input logic            cfg_clk_en,
    input logic            clr_start,
    input tap_st_e         st_q,
    input logic [IR_W-1:0] ir_sh,
    input logic            fail_q
);
    a_r2_ir_shift_in: assert property (@(posedge tck) disable iff (!prog_n)
        $past(st_q) == ST_SH_IR |-> ir_sh[IR_W-1] == $past(tdi));

    a_r3_clr_one_cycle: assert property (@(posedge tck) disable iff (!prog_n)
        clr_start |=> !clr_start);

    a_r3_clr_from_update: assert property (@(posedge tck) disable iff (!prog_n)
        clr_start |-> $past(st_q) == ST_UPD_IR);

    a_r4_clk_gate: assert property (@(posedge tck) disable iff (!prog_n)
        cfg_clk_en |-> (init_rel && st_q == ST_SH_DR));

    a_r10_no_clk_after_fail: assert property (@(posedge tck) disable iff (!prog_n)
        fail_q |-> (!cfg_clk_en && !clr_start));
endmodule

bind jtc_cfg_tap jtc_cfg_tap_chk u_chk (
    .tck(tck), .prog_n(prog_n), .tdi(tdi), .init_rel(init_rel),
    .cfg_clk_en(cfg_clk_en), .clr_start(clr_start), .st_q(st_q),
    .ir_sh(ir_sh), .fail_q(q.fail)
);

// File: tb/jtc_cfg_tap_tb_top.sv
`timescale 1ns/1ps
module jtc_cfg_tap_tb_top;
    logic tck = 1'b0, prog_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic init_rel = 1'b0, cfg_done = 1'b0, cfg_fail = 1'b0;
    logic tdo, dout, cfg_clk_en, clr_start;
    int   n_chk = 0, n_bad = 0;
    bit   fin = 1'b0;

    always #2 tck = ~tck;

    jtc_cfg_tap dut_i (.*);

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drv(input logic m, input logic i);
        @(negedge tck);
        tms = m; tdi = i;
        #1;
    endtask

    task automatic load_ir(input logic [2:0] op, input bit chk_cap);
        drv(1, 0); drv(1, 0); drv(0, 0); drv(0, 0);
        drv(0, op[0]); if (chk_cap) chk("R2 capture bit0", tdo, 1'b1);
        drv(0, op[1]); if (chk_cap) chk("R2 capture bit1", tdo, 1'b0);
        drv(1, op[2]); if (chk_cap) chk("R2 capture bit2", tdo, 1'b0);
        drv(1, 0);
        drv(0, 0);
    endtask

    task automatic goto_sdr();
        drv(1, 0); drv(0, 0); drv(0, 0);
    endtask

    task automatic exit_sdr();
        drv(1, 0); drv(1, 0); drv(0, 0);
    endtask

    function automatic logic exp_clr(input bit accepted);
        return accepted ? 1'b1 : 1'b0;
    endfunction

    task automatic chk_clr(input string req, input bit accepted);
        drv(0, 0); chk(req, clr_start, exp_clr(accepted));
        drv(0, 0); chk(req, clr_start, 1'b0);
    endtask

    task automatic bypass_run(input string req, input int n);
        logic prev;
        goto_sdr();
        prev = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic b;
            b = 1'($urandom);
            drv(0, b);
            chk(req, tdo, prev);
            prev = b;
        end
        exit_sdr();
    endtask

    task automatic cfg_probe(input string req, input logic exp_en);
        goto_sdr();
        drv(0, 1); chk(req, cfg_clk_en, exp_en);
        exit_sdr();
    endtask

    initial begin
        void'($urandom(32'd4711));
        #9;
        chk("R1 reset tdo", tdo, 1'b0);
        chk("R6 reset dout", dout, 1'b1);
        chk("R4 reset clk_en", cfg_clk_en, 1'b0);
        chk("R3 reset clr", clr_start, 1'b0);
        @(negedge tck); prog_n = 1'b1;
        drv(0, 0);

        load_ir(3'b111, 1);
        chk_clr("R3 bypass no clr", 0);
        bypass_run("R5 bypass delay", 20);
        load_ir(3'b010, 0);
        bypass_run("R5 unknown opcode", 20);
        load_ir(3'b001, 0);
        bypass_run("R5 sample", 8);

        // R11: unlocked configure dropped by Test-Logic-Reset
        load_ir(3'b101, 0);
        chk_clr("R3 configure clr", 1);
        cfg_probe("R4 no init_rel", 1'b0);
        repeat (5) drv(1, 0);
        drv(0, 0);
        init_rel = 1'b1;
        cfg_probe("R11 TLR to bypass", 1'b0);
        init_rel = 1'b0;

        // full stream
        load_ir(3'b101, 0);
        chk_clr("R3 configure clr 2", 1);
        init_rel = 1'b1;
        drv(0, 0); chk("R4 idle no clk", cfg_clk_en, 1'b0);
        goto_sdr();
        for (int k = 0; k < 8; k++) begin
            drv(0, 1); chk("R6 echo ones", dout, 1'b1); chk("R4 clk_en", cfg_clk_en, 1'b1);
        end
        drv(0, 0); chk("R6 echo pre", dout, 1'b0); chk("R6 tdo echo", tdo, 1'b0);
        drv(0, 0); chk("R6 echo pre", dout, 1'b0);
        drv(0, 1); chk("R6 echo pre", dout, 1'b1);
        drv(0, 0); chk("R6 echo pre", dout, 1'b0);
        for (int k = 0; k < 24; k++) begin
            logic b;
            b = 1'($urandom);
            drv(0, b); chk("R7 echo length", dout, b);
        end
        drv(0, 0); chk("R7 dout held", dout, 1'b1); chk("R7 tdo held", tdo, 1'b1);
        drv(0, 0); chk("R7 dout held", dout, 1'b1);
        exit_sdr();

        // R8 lock
        load_ir(3'b001, 0);
        cfg_probe("R8 sample ignored", 1'b1);
        repeat (5) drv(1, 0);
        drv(0, 0);
        cfg_probe("R8 TLR ignored", 1'b1);
        cfg_done = 1'b1; drv(0, 0); cfg_done = 1'b0;
        load_ir(3'b111, 0);
        cfg_probe("R8 released", 1'b0);

        // R9 cancel
        load_ir(3'b101, 0);
        chk_clr("R9 fresh configure", 1);
        load_ir(3'b101, 0);
        chk_clr("R9 cancel no clr", 0);
        cfg_probe("R9 cancelled", 1'b0);
        load_ir(3'b101, 0);
        chk_clr("R9 reissue", 1);
        cfg_probe("R9 reissue active", 1'b1);

        // R10 failure
        cfg_fail = 1'b1; drv(0, 0); cfg_fail = 1'b0;
        cfg_probe("R10 fail to bypass", 1'b0);
        load_ir(3'b101, 0);
        chk_clr("R10 configure refused", 0);
        cfg_probe("R10 still bypass", 1'b0);
        @(negedge tck); prog_n = 1'b0; #1; prog_n = 1'b1;
        drv(0, 0);
        load_ir(3'b101, 0);
        chk_clr("R10 after reset", 1);
        cfg_probe("R10 configure back", 1'b1);

        fin = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!fin) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule